// File: doc/BRIEF.md
# Serial Flash Continuous-Read Target

This block is the target end of a four-wire serial memory link. It answers the two continuous array read commands from a page-organised memory and ignores every other command. While chip select is low it samples the command byte, a 24-bit address and, for the fast variant, one dummy byte on `si_i`, one bit per rising SCK edge, most significant bit first. It then streams the stored bytes out on `so_o`, MSB first, for as long as the master keeps clocking. A new bit appears after each falling SCK edge, so the master samples it on the rising edge.

Two page layouts are supported. In padded mode a page holds 1056 bytes and the address splits into a page field and a byte field. In power-of-two mode a page holds 1024 bytes and the address is a linear byte address. In both modes the stream runs on from the last byte of a page into the next page, and from the last byte of the array back to page 0, without losing a clock. The array contents are a fixed function of page and byte, so the block stores no data. All link inputs are sampled with the fabric clock `clk_i`, which must run at least six times faster than SCK. The SO tristate is represented by `so_o` together with the enable `so_oe_o`.

Top module: `sflash_rd_target`

## Requirements
- R1: After reset, and from one `clk_i` cycle after `cs_ni` rises, `so_oe_o` is 0. A rise of `cs_ni` ends any command. The next fall of `cs_ni` starts a new command.
- R2: The command byte is taken from `si_i` on the first 8 rising SCK edges, MSB first. Value 0x03 is followed by 24 address bits (MSB first) and then by data.
- R3: Value 0x0B is followed by 24 address bits and then 8 don't-care bits before data. `so_oe_o` stays 0 during all command, address and dummy bits.
- R4: Each data byte goes out MSB first. `so_o` changes only in the `clk_i` cycle after a falling SCK edge. `so_oe_o` rises with the first data bit, which is driven on the falling edge that follows the last address or dummy bit.
- R5: With `page_mode_i`=0 (padded), pages are 1056 bytes long. Address bits 23:11 give the page, taken modulo `NUM_PAGES`, and bits 10:0 give the starting byte.
- R6: With `page_mode_i`=1 (power-of-two), pages are 1024 bytes long. Address bits 22:10 give the page, taken modulo `NUM_PAGES`, bits 9:0 give the byte, and bit 23 is ignored. `page_mode_i` is held stable while chip select is low.
- R7: After the last byte of a page, the next byte out is byte 0 of the following page, with no extra SCK cycles.
- R8: After the last byte of page `NUM_PAGES`-1, the next byte out is byte 0 of page 0, with no extra SCK cycles.
- R9: In padded mode a starting byte field of 1056 or more is treated as the end of the page. The first byte out is byte 0 of the next page, which wraps to page 0 after the last page.
- R10: Any other command value is ignored. `so_oe_o` stays 0 for the rest of that selection, however many clocks follow.
- R11: The byte at page p, byte b is b[7:0] XOR {b[10:8], p[4:0]} XOR `SEED`. The default `SEED` is 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock that samples the serial link |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master (idle low) |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| page_mode_i | input | 1 | 0: 1056-byte pages; 1: 1024-byte pages |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` (0 = high impedance) |

## Verification
The read commands are tried with starting points chosen to tell the layouts and the boundary paths apart. A mid-page start with the slow command checks the address split and the pattern. Starts two bytes before a page end, in both modes, distinguish the 1056 and 1024 page limits and show a seamless page crossing. Starts on the last page check the wrap to page 0. An oversized byte field checks the fold, and page fields above the array check the modulo. An unknown opcode followed by many clocks must leave the output released. A chip-select rise in the middle of a byte must release it at once, and the command that follows must start cleanly.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] OP_SLOW = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam int ADDR_BITS = 24;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } cmd_st_e;
endpackage

// File: rtl/sfr_edge_det.sv
module sfr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/sfr_cmd_rx.sv
module sfr_cmd_rx
  import sfr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 si_i,
  input  logic                 rise_i,
  output cmd_st_e              st_o,
  output logic [ADDR_BITS-1:0] addr_o,
  output logic                 addr_vld_o
);
  localparam int CNT_W = $clog2(ADDR_BITS);

  cmd_st_e              st_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [7:0]           op_sr;
  logic [ADDR_BITS-1:0] ad_sr;
  logic                 fast_q;
  logic                 vld_q;
  logic [7:0]           op_nx;
  logic [ADDR_BITS-1:0] ad_nx;

  assign op_nx = {op_sr[6:0], si_i};
  assign ad_nx = {ad_sr[ADDR_BITS-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OP;
      cnt_q  <= '0;
      op_sr  <= '0;
      ad_sr  <= '0;
      fast_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (cs_ni) begin
      st_q  <= ST_OP;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (rise_i) begin
        case (st_q)
          ST_OP: begin
            op_sr <= op_nx;
            if (cnt_q == CNT_W'(7)) begin
              cnt_q <= '0;
              if (op_nx == OP_SLOW) begin
                st_q   <= ST_ADDR;
                fast_q <= 1'b0;
              end else if (op_nx == OP_FAST) begin
                st_q   <= ST_ADDR;
                fast_q <= 1'b1;
              end else begin
                st_q <= ST_IGNORE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            ad_sr <= ad_nx;
            if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
              cnt_q <= '0;
              vld_q <= 1'b1;
              st_q  <= fast_q ? ST_DUMMY : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DUMMY: begin
            if (cnt_q == CNT_W'(7)) begin
              cnt_q <= '0;
              st_q  <= ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o       = st_q;
  assign addr_o     = ad_sr;
  assign addr_vld_o = vld_q;

  AST_ADDR_NEEDS_READ_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && $past(st_q) == ST_OP) |-> (op_sr == OP_SLOW || op_sr == OP_FAST)); // R10
  AST_DUMMY_ONLY_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DUMMY) |-> (fast_q && op_sr == OP_FAST)); // R3
  AST_SLOW_SKIPS_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && $past(st_q) == ST_ADDR) |-> (op_sr == OP_SLOW)); // R2
endmodule

// File: rtl/sfr_addr_seq.sv
module sfr_addr_seq
  import sfr_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int PAD_BYTES = 1056,
  parameter int P2_BYTES  = 1024,
  localparam int PAGE_AW  = $clog2(NUM_PAGES),
  localparam int BYTE_W   = $clog2(PAD_BYTES),
  localparam int P2_BW    = $clog2(P2_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic                 load_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic                 adv_i,
  output logic [PAGE_AW-1:0]   page_o,
  output logic [BYTE_W-1:0]    byte_o
);
  logic [PAGE_AW-1:0] page_q, ld_page;
  logic [BYTE_W-1:0]  byte_q, ld_byte, last_byte;

  assign last_byte = mode_i ? BYTE_W'(P2_BYTES - 1) : BYTE_W'(PAD_BYTES - 1);

  always_comb begin
    if (mode_i) begin
      ld_page = addr_i[P2_BW +: PAGE_AW];
      ld_byte = BYTE_W'(addr_i[P2_BW-1:0]);
    end else begin
      ld_page = addr_i[BYTE_W +: PAGE_AW];
      ld_byte = addr_i[BYTE_W-1:0];
      if (addr_i[BYTE_W-1:0] > BYTE_W'(PAD_BYTES - 1)) begin
        ld_page = addr_i[BYTE_W +: PAGE_AW] + 1'b1;
        ld_byte = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      page_q <= ld_page;
      byte_q <= ld_byte;
    end else if (adv_i) begin
      if (byte_q == last_byte) begin
        byte_q <= '0;
        page_q <= page_q + 1'b1;
      end else begin
        byte_q <= byte_q + 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign byte_o = byte_q;

  AST_LOAD_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (byte_q <= last_byte)); // R9
  AST_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && byte_q == last_byte) |=>
      (byte_q == '0 && page_q == PAGE_AW'($past(page_q) + 1'b1))); // R7
  AST_ARRAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && byte_q == last_byte && page_q == PAGE_AW'(NUM_PAGES - 1)) |=>
      (page_q == '0 && byte_q == '0)); // R8
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && byte_q != last_byte) |=> (byte_q == BYTE_W'($past(byte_q) + 1'b1))); // R7
endmodule

// File: rtl/sfr_pattern.sv
module sfr_pattern #(
  parameter int          PAGE_AW = 2,
  parameter int          BYTE_W  = 11,
  parameter logic [7:0]  SEED    = 8'hA5
) (
  input  logic [PAGE_AW-1:0] page_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [7:0]         data_o
);
  logic [4:0] pg5;

  assign pg5    = 5'(page_i);
  assign data_o = byte_i[7:0] ^ {byte_i[BYTE_W-1 -: 3], pg5} ^ SEED;
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       fall_i,
  input  logic       data_phase_i,
  input  logic [7:0] byte_i,
  output logic       so_o,
  output logic       oe_o,
  output logic       adv_o
);
  logic [7:0] sr_q;
  logic [2:0] bcnt_q;
  logic       so_q, oe_q, adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= 1'b0;
      if (cs_ni) begin
        oe_q   <= 1'b0;
        bcnt_q <= '0;
      end else if (fall_i && data_phase_i) begin
        oe_q   <= 1'b1;
        bcnt_q <= bcnt_q + 1'b1;
        if (bcnt_q == 3'd0) begin
          so_q  <= byte_i[7];
          sr_q  <= {byte_i[6:0], 1'b0};
          adv_q <= 1'b1;  // fetch point moves on as soon as a byte is taken
        end else begin
          so_q <= sr_q[7];
          sr_q <= {sr_q[6:0], 1'b0};
        end
      end
    end
  end

  assign so_o  = so_q;
  assign oe_o  = oe_q;
  assign adv_o = adv_q;

  AST_SO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(so_q)); // R4
  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(fall_i)); // R4
endmodule

// File: rtl/sflash_rd_target.sv
module sflash_rd_target
  import sfr_pkg::*;
#(
  parameter int         NUM_PAGES = 4,
  parameter int         PAD_BYTES = 1056,
  parameter int         P2_BYTES  = 1024,
  parameter logic [7:0] SEED      = 8'hA5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic page_mode_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int PAGE_AW = $clog2(NUM_PAGES);
  localparam int BYTE_W  = $clog2(PAD_BYTES);

  logic                 sck_rise, sck_fall;
  cmd_st_e              cmd_st;
  logic [ADDR_BITS-1:0] cmd_addr;
  logic                 cmd_addr_vld;
  logic [PAGE_AW-1:0]   cur_page;
  logic [BYTE_W-1:0]    cur_byte;
  logic [7:0]           cur_data;
  logic                 tx_adv;

  sfr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  sfr_cmd_rx u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .si_i       (si_i),
    .rise_i     (sck_rise),
    .st_o       (cmd_st),
    .addr_o     (cmd_addr),
    .addr_vld_o (cmd_addr_vld)
  );

  sfr_addr_seq #(
    .NUM_PAGES (NUM_PAGES),
    .PAD_BYTES (PAD_BYTES),
    .P2_BYTES  (P2_BYTES)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (page_mode_i),
    .load_i (cmd_addr_vld),
    .addr_i (cmd_addr),
    .adv_i  (tx_adv),
    .page_o (cur_page),
    .byte_o (cur_byte)
  );

  sfr_pattern #(
    .PAGE_AW (PAGE_AW),
    .BYTE_W  (BYTE_W),
    .SEED    (SEED)
  ) u_pat (
    .page_i (cur_page),
    .byte_i (cur_byte),
    .data_o (cur_data)
  );

  sfr_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .fall_i       (sck_fall),
    .data_phase_i (cmd_st == ST_DATA),
    .byte_i       (cur_data),
    .so_o         (so_o),
    .oe_o         (so_oe_o),
    .adv_o        (tx_adv)
  );

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> !so_oe_o); // R1
  AST_IGNORED_OP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_st == ST_IGNORE) |-> !so_oe_o); // R10
  AST_OE_ONLY_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (cmd_st == ST_DATA)); // R3
endmodule

// File: tb/tb_sflash_rd_target.sv
module tb_sflash_rd_target;
  localparam int         NP   = 4;
  localparam int         H    = 3;
  localparam logic [7:0] SEED = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, pmode = 1'b0;
  logic so, so_oe;

  int  n_chk = 0, n_fail = 0;
  bit  chk_en = 1'b0;
  bit  exp_oe = 1'b0;

  always #2 clk = ~clk;

  sflash_rd_target #(.NUM_PAGES(NP), .SEED(SEED)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sck_i       (sck),
    .cs_ni       (cs_n),
    .si_i        (si),
    .page_mode_i (pmode),
    .so_o        (so),
    .so_oe_o     (so_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock model of the output enable
  always @(posedge clk) begin
    #1;
    if (chk_en) check(so_oe === exp_oe, "R1/R3/R4/R10 oe per clock", 32'(so_oe), 32'(exp_oe));
  end

  function automatic logic [7:0] pat(input int pg, input int by);
    logic [10:0] b = 11'(by);
    logic [4:0]  p = 5'(pg);
    return b[7:0] ^ {b[10:8], p} ^ SEED;
  endfunction

  task automatic sck_cycle(input logic din, output logic dout);
    si = din;
    repeat (H) @(negedge clk);
    dout = so;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic deselect(input string tag);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    exp_oe = 1'b0;
    repeat (2) @(negedge clk);
    check(so_oe === 1'b0, {"R1 release ", tag}, 32'(so_oe), 0);
    repeat (2) @(negedge clk);
  endtask

  // cut_bits < 0: read nbytes whole bytes; otherwise stop after cut_bits data bits
  task automatic do_read(input logic [7:0] op, input bit mode, input logic [23:0] addr,
                         input int nbytes, input int cut_bits, input string tag);
    logic s;
    int   pg, by, lim;
    bit   valid;
    valid = (op == 8'h03) || (op == 8'h0B);
    pmode = mode;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 7; i >= 0; i--) sck_cycle(op[i], s);
    if (!valid) begin
      for (int i = 0; i < 40; i++) sck_cycle(1'b1, s);
      check(so_oe === 1'b0, {"R10 ignored op ", tag}, 32'(so_oe), 0);
      deselect(tag);
      return;
    end
    for (int i = 23; i >= 0; i--) sck_cycle(addr[i], s);
    if (op == 8'h0B) for (int i = 0; i < 8; i++) sck_cycle(1'b1, s);
    exp_oe = 1'b1;
    if (mode) begin
      lim = 1024; pg = int'(addr[22:10]) % NP; by = int'(addr[9:0]);
    end else begin
      lim = 1056; pg = int'(addr[23:11]) % NP; by = int'(addr[10:0]);
      if (by >= 1056) begin by = 0; pg = (pg + 1) % NP; end
    end
    if (cut_bits >= 0) begin
      for (int i = 0; i < cut_bits; i++) sck_cycle(1'b0, s);
      check(so_oe === 1'b1, {"R4 oe before abort ", tag}, 32'(so_oe), 1);
      deselect(tag);
      return;
    end
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] got, exp;
      got = '0;
      for (int b = 0; b < 8; b++) begin
        sck_cycle(1'b0, s);
        got = {got[6:0], s};
      end
      exp = pat(pg, by);
      check(got === exp, $sformatf("%s byte%0d p%0d b%0d", tag, k, pg, by), 32'(got), 32'(exp));
      if (by == lim - 1) begin by = 0; pg = (pg + 1) % NP; end
      else by++;
    end
    deselect(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(so_oe === 1'b0, "R1 oe in reset", 32'(so_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(so_oe === 1'b0, "R1 oe after reset", 32'(so_oe), 0);
    chk_en = 1'b1;

    do_read(8'h03, 1'b0, {13'd1, 11'd5},    4, -1, "R2 R5 R11 slow padded");
    do_read(8'h0B, 1'b0, {13'd2, 11'd1054}, 4, -1, "R3 R7 fast padded page cross");
    do_read(8'h03, 1'b0, {13'd3, 11'd1054}, 4, -1, "R8 padded array wrap");
    do_read(8'h0B, 1'b0, {13'd1, 11'd1500}, 3, -1, "R9 fold to next page");
    do_read(8'h03, 1'b0, {13'd3, 11'd2047}, 2, -1, "R9 fold with wrap");
    do_read(8'h03, 1'b1, 24'(2*1024 + 1022), 4, -1, "R6 R7 pow2 page cross");
    do_read(8'h0B, 1'b1, 24'(3*1024 + 1023), 3, -1, "R8 pow2 array wrap");
    do_read(8'h03, 1'b1, 24'h800000 | 24'(5*1024 + 7), 2, -1, "R6 pow2 page modulo");
    do_read(8'h9F, 1'b0, 24'h0, 0, -1, "R10");
    do_read(8'h0B, 1'b0, {13'd0, 11'd3}, 2, -1, "R10 read after ignored op");
    do_read(8'h03, 1'b0, {13'd2, 11'd9}, 0, 3, "R1 abort mid byte");
    do_read(8'h03, 1'b0, {13'd2, 11'd9}, 2, -1, "R1 fresh read after abort");
    do_read(8'h0B, 1'b0, {13'd6, 11'd0}, 2, -1, "R5 padded page modulo");

    chk_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule